// File: doc/BRIEF.md
# Three-Plane Nozzle Firing Scan Controller

This block drives the heater array of a thermal inkjet die of up to a thousand nozzles. Every heater lies where one power line, one address line and one select line meet. There are ten lines in each of the three groups. A heater conducts only while its three lines are asserted together. The controller sees four control inputs: a serial data bit, a bit-shift strobe, a fire-enable strobe that opens the firing window, and a synchronous clear. It also takes a fire pulse width. Its outputs are the thirty line enables and a one-cycle completion flag.

Fire data are shifted serially into a shift register of one bit per nozzle. A rising edge of the fire-enable strobe copies that register into a fire latch and starts a scan. The next image can then be shifted in while the scan runs. The scan visits the ten power planes in turn. Within a plane it steps one address line at a time and, for each slot, drives the select lines with the latched bits of the ten nozzles in that slot. Each heater is therefore selected by an exact three-way coincidence and fires once per print cycle.

Nozzle number n belongs to power line n/100, address line (n/10)%10 and select line n%10. It occupies bit n of both the shift register and the fire latch.

Top module: `nozzle_scan3d`

## Requirements
- R1: After reset, all power, address and select outputs are low and the done flag is low.
- R2: Each rising edge of the bit-shift strobe, sampled on the clock, shifts in one data bit. The stream carries nozzle 999 first and nozzle 0 last, so nozzle n lands at bit n.
- R3: A rising edge of the fire-enable strobe copies the shift register into the fire latch and starts a scan. From the next clock cycle, power line 0 and address line 0 are asserted.
- R4: A scan has one hundred slots, each held for pulse-width cycles. The power index is the outer loop and the address index the inner loop, both counted upward. In every slot exactly one power line and one address line are high. The select lines carry latch bits 100p+10a+0 through 100p+10a+9, with select line k carrying bit 100p+10a+k.
- R5: Over one scan, the set of nozzles whose power, address and select lines are seen high together equals the set of ones in the latched image.
- R6: The done flag is high for exactly one cycle: the cycle right after the last slot. All line outputs are low in that cycle.
- R7: A fire-enable edge while the pulse width is 0 asserts no line and produces no done pulse.
- R8: A clear stops any scan. In the next cycle all line outputs and the done flag are low, and the shift register and fire latch are zero.
- R9: Shifting new data during a scan does not alter the pattern being fired.
- R10: If a shift edge and a fire-enable edge fall in the same cycle, the latch takes the register contents from before that shift, and the new bit stays in the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Bit-shift strobe; rising edge shifts one bit |
| sdata_i | input | 1 | Serial fire data |
| fire_en_i | input | 1 | Fire-enable strobe; rising edge latches and starts a scan |
| clear_i | input | 1 | Synchronous clear of all state |
| pulse_width_i | input | PW_W | Cycles per slot, captured at scan start |
| p_line_o | output | LINES | Power line enables |
| a_line_o | output | LINES | Address line enables |
| s_line_o | output | LINES | Select line enables |
| done_o | output | 1 | One-cycle pulse after the final slot |

## Verification
Two functions can fall in the same clock cycle. One is a shift, which loads the register. The other is a latch transfer, which reads the register. The bench raises the bit-shift strobe and the fire-enable strobe on the same edge, right after a full image has been loaded. It then checks that the scan fires the old image. A second fire with no further shifting must then fire that image moved up by one place with a one at nozzle 0. The same overlap is also exercised over a long span: a complete image is shifted in while a slow scan is running, and both images are compared with what was injected.

// File: rtl/ns3_pkg.sv
package ns3_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_FIRE = 1'b1
    } seq_mode_e;

    function automatic int unsigned cube(input int unsigned n);
        return n * n * n;
    endfunction

endpackage

// File: rtl/ns3_shift_in.sv
module ns3_shift_in #(
    parameter int unsigned NOZ = 1000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear_i,
    input  logic           sclk_i,
    input  logic           sdata_i,
    output logic [NOZ-1:0] sr_o
);

    typedef struct packed {
        logic           sclk_prev;
        logic [NOZ-1:0] sr;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d           = shf_q;
        shf_d.sclk_prev = sclk_i;
        if (clear_i) begin
            shf_d.sr = '0;
        end else if (sclk_i && !shf_q.sclk_prev) begin
            shf_d.sr = {shf_q.sr[NOZ-2:0], sdata_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q <= '0;
        end else begin
            shf_q <= shf_d;
        end
    end

    assign sr_o = shf_q.sr;

endmodule

// File: rtl/ns3_fire_latch.sv
module ns3_fire_latch #(
    parameter int unsigned NOZ = 1000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear_i,
    input  logic           fire_en_i,
    input  logic [NOZ-1:0] sr_i,
    output logic           start_o,
    output logic [NOZ-1:0] latch_o
);

    typedef struct packed {
        logic           en_prev;
        logic [NOZ-1:0] img;
    } lat_t;

    lat_t lat_d, lat_q;
    logic rise;

    always_comb begin
        rise          = fire_en_i && !lat_q.en_prev && !clear_i;
        lat_d         = lat_q;
        lat_d.en_prev = fire_en_i;
        if (clear_i) begin
            lat_d.img = '0;
        end else if (rise) begin
            lat_d.img = sr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign start_o = rise;
    assign latch_o = lat_q.img;

endmodule

// File: rtl/ns3_sequencer.sv
module ns3_sequencer
    import ns3_pkg::*;
#(
    parameter int unsigned LINES = 10,
    parameter int unsigned PW_W  = 8,
    localparam int unsigned IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             start_i,
    input  logic [PW_W-1:0]  pw_i,
    output logic             active_o,
    output logic [IDX_W-1:0] p_idx_o,
    output logic [IDX_W-1:0] a_idx_o,
    output logic             done_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

    typedef struct packed {
        seq_mode_e        mode;
        logic [IDX_W-1:0] p;
        logic [IDX_W-1:0] a;
        logic [PW_W-1:0]  cnt;
        logic [PW_W-1:0]  pw;
        logic             done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (clear_i) begin
            seq_d = '0;
        end else if (start_i) begin
            seq_d.p   = '0;
            seq_d.a   = '0;
            seq_d.cnt = '0;
            seq_d.pw  = pw_i;
            seq_d.mode = (pw_i == '0) ? SEQ_IDLE : SEQ_FIRE;
        end else if (seq_q.mode == SEQ_FIRE) begin
            if (seq_q.cnt == seq_q.pw - PW_W'(1)) begin
                seq_d.cnt = '0;
                if (seq_q.a == LAST_IDX) begin
                    seq_d.a = '0;
                    if (seq_q.p == LAST_IDX) begin
                        seq_d.p    = '0;
                        seq_d.mode = SEQ_IDLE;
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.p = seq_q.p + IDX_W'(1);
                    end
                end else begin
                    seq_d.a = seq_q.a + IDX_W'(1);
                end
            end else begin
                seq_d.cnt = seq_q.cnt + PW_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign active_o = (seq_q.mode == SEQ_FIRE);
    assign p_idx_o  = seq_q.p;
    assign a_idx_o  = seq_q.a;
    assign done_o   = seq_q.done;

endmodule

// File: rtl/ns3_line_driver.sv
module ns3_line_driver #(
    parameter int unsigned LINES = 10,
    localparam int unsigned IDX_W = $clog2(LINES),
    localparam int unsigned NOZ   = LINES * LINES * LINES
) (
    input  logic             active_i,
    input  logic [IDX_W-1:0] p_idx_i,
    input  logic [IDX_W-1:0] a_idx_i,
    input  logic [NOZ-1:0]   latch_i,
    output logic [LINES-1:0] p_o,
    output logic [LINES-1:0] a_o,
    output logic [LINES-1:0] s_o
);

    int unsigned base;

    always_comb begin
        base = (int'(p_idx_i) * LINES + int'(a_idx_i)) * LINES;
        p_o  = '0;
        a_o  = '0;
        s_o  = '0;
        if (active_i) begin
            for (int unsigned k = 0; k < LINES; k++) begin
                p_o[k] = (int'(p_idx_i) == int'(k));
                a_o[k] = (int'(a_idx_i) == int'(k));
                s_o[k] = latch_i[base + k];
            end
        end
    end

endmodule

// File: rtl/nozzle_scan3d.sv
module nozzle_scan3d #(
    parameter int unsigned LINES = 10,
    parameter int unsigned PW_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic             sdata_i,
    input  logic             fire_en_i,
    input  logic             clear_i,
    input  logic [PW_W-1:0]  pulse_width_i,
    output logic [LINES-1:0] p_line_o,
    output logic [LINES-1:0] a_line_o,
    output logic [LINES-1:0] s_line_o,
    output logic             done_o
);

    localparam int unsigned NOZ   = ns3_pkg::cube(LINES);
    localparam int unsigned IDX_W = $clog2(LINES);

    logic [NOZ-1:0]   sr;
    logic [NOZ-1:0]   latch;
    logic             start;
    logic             active;
    logic [IDX_W-1:0] p_idx;
    logic [IDX_W-1:0] a_idx;

    ns3_shift_in #(.NOZ(NOZ)) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .sclk_i  (sclk_i),
        .sdata_i (sdata_i),
        .sr_o    (sr)
    );

    ns3_fire_latch #(.NOZ(NOZ)) latch_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_i),
        .fire_en_i (fire_en_i),
        .sr_i      (sr),
        .start_o   (start),
        .latch_o   (latch)
    );

    ns3_sequencer #(.LINES(LINES), .PW_W(PW_W)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear_i),
        .start_i  (start),
        .pw_i     (pulse_width_i),
        .active_o (active),
        .p_idx_o  (p_idx),
        .a_idx_o  (a_idx),
        .done_o   (done_o)
    );

    ns3_line_driver #(.LINES(LINES)) drv_i (
        .active_i (active),
        .p_idx_i  (p_idx),
        .a_idx_i  (a_idx),
        .latch_i  (latch),
        .p_o      (p_line_o),
        .a_o      (a_line_o),
        .s_o      (s_line_o)
    );

endmodule

// File: rtl/ns3_checker.sv
module ns3_checker #(
    parameter int unsigned LINES = 10,
    parameter int unsigned PW_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fire_en_i,
    input logic             clear_i,
    input logic [PW_W-1:0]  pulse_width_i,
    input logic [LINES-1:0] p_line_o,
    input logic [LINES-1:0] a_line_o,
    input logic [LINES-1:0] s_line_o,
    input logic             done_o
);

    // R4
    p_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(p_line_o) && $onehot0(a_line_o));

    // R4
    planes_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_line_o == '0) |-> (a_line_o == '0 && s_line_o == '0));

    // R4
    p_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(p_line_o) != '0 && p_line_o != '0 && p_line_o != $past(p_line_o)
         && p_line_o != LINES'(1)) |-> (p_line_o == ($past(p_line_o) << 1)));

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (p_line_o == '0 && a_line_o == '0 && s_line_o == '0));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (p_line_o == '0 && a_line_o == '0 && s_line_o == '0 && !done_o));

    // R7
    zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_en_i && !$past(fire_en_i) && pulse_width_i == '0) |=> (p_line_o == '0));

endmodule

bind nozzle_scan3d ns3_checker #(.LINES(LINES), .PW_W(PW_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .fire_en_i     (fire_en_i),
    .clear_i       (clear_i),
    .pulse_width_i (pulse_width_i),
    .p_line_o      (p_line_o),
    .a_line_o      (a_line_o),
    .s_line_o      (s_line_o),
    .done_o        (done_o)
);

// File: tb/nozzle_scan3d_tb_top.sv
`timescale 1ns/1ps
module nozzle_scan3d_tb_top;

    localparam int LINES = 10;
    localparam int PW_W  = 8;
    localparam int NOZ   = 1000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sclk_i = 1'b0;
    logic             sdata_i = 1'b0;
    logic             fire_en_i = 1'b0;
    logic             clear_i = 1'b0;
    logic [PW_W-1:0]  pulse_width_i = '0;
    logic [LINES-1:0] p_line_o, a_line_o, s_line_o;
    logic             done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [NOZ-1:0] last_fired;

    always #2.5 clk = ~clk;

    nozzle_scan3d #(.LINES(LINES), .PW_W(PW_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdata_i(sdata_i),
        .fire_en_i(fire_en_i), .clear_i(clear_i), .pulse_width_i(pulse_width_i),
        .p_line_o(p_line_o), .a_line_o(a_line_o), .s_line_o(s_line_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input logic [1023:0] act,
                       input logic [1023:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    function automatic logic [NOZ-1:0] lfsr_map(input logic [31:0] seed);
        logic [NOZ-1:0] m;
        logic [31:0] s = seed;
        for (int i = 0; i < NOZ; i++) begin
            s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
            m[i] = s[3];
        end
        return m;
    endfunction

    // R2: stream nozzle 999 first
    task automatic shift_in(input logic [NOZ-1:0] img);
        for (int n = NOZ - 1; n >= 0; n--) begin
            @(negedge clk);
            sdata_i = img[n];
            sclk_i  = 1'b1;
            @(negedge clk);
            sclk_i  = 1'b0;
        end
    endtask

    // R3 R4 R5 R6 checked per scan
    task automatic fire_and_watch(input int pw, input logic [NOZ-1:0] exp, input bit also_shift);
        int slot_err = 0;
        int done_err = 0;
        logic [NOZ-1:0] fired = '0;
        @(negedge clk);
        pulse_width_i = PW_W'(pw);
        fire_en_i = 1'b1;
        if (also_shift) begin
            sdata_i = 1'b1;
            sclk_i  = 1'b1;
        end
        for (int i = 1; i <= 100 * pw + 2; i++) begin
            @(negedge clk);
            if (i == 1) begin
                fire_en_i = 1'b0;
                sclk_i    = 1'b0;
                chk(p_line_o == 10'd1 && a_line_o == 10'd1, "R3",
                    {p_line_o, a_line_o}, {10'd1, 10'd1});
            end
            for (int p = 0; p < LINES; p++)
                for (int a = 0; a < LINES; a++)
                    for (int s = 0; s < LINES; s++)
                        if (p_line_o[p] && a_line_o[a] && s_line_o[s])
                            fired[p*100 + a*10 + s] = 1'b1;
            if (i <= 100 * pw) begin
                int idx = (i - 1) / pw;
                int ep = idx / 10;
                int ea = idx % 10;
                if (p_line_o != (10'd1 << ep) || a_line_o != (10'd1 << ea) ||
                    s_line_o != exp[idx*10 +: 10] || done_o)
                    slot_err++;
            end else if (i == 100 * pw + 1) begin
                if (!done_o || p_line_o != 0 || a_line_o != 0 || s_line_o != 0) done_err++;
            end else begin
                if (done_o) done_err++;
            end
        end
        chk(slot_err == 0, "R4", slot_err, 0);
        chk(fired == exp, "R5", fired, exp);
        chk(done_err == 0, "R6", done_err, 0);
        last_fired = fired;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(p_line_o == 0 && a_line_o == 0 && s_line_o == 0 && !done_o, "R1",
            {p_line_o, a_line_o, s_line_o, done_o}, 0);
    endtask

    task automatic t_patterns();
        logic [NOZ-1:0] m = '0;
        m[0] = 1; m[1] = 1; m[123] = 1; m[555] = 1; m[999] = 1; m[90] = 1;
        shift_in(m);
        fire_and_watch(2, m, 0);
        chk(last_fired[999] && last_fired[0] && last_fired[123], "R2", last_fired, m);
        shift_in({NOZ{1'b1}});
        fire_and_watch(1, {NOZ{1'b1}}, 0);
        m = lfsr_map(32'h1d2c_3b4a);
        shift_in(m);
        fire_and_watch(3, m, 0);
    endtask

    task automatic t_zero_width();
        int seen = 0;
        shift_in(lfsr_map(32'h0bad_cafe));
        @(negedge clk);
        pulse_width_i = '0;
        fire_en_i = 1'b1;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            fire_en_i = 1'b0;
            if (p_line_o != 0 || a_line_o != 0 || s_line_o != 0 || done_o) seen++;
        end
        chk(seen == 0, "R7", seen, 0);
    endtask

    task automatic t_clear();
        shift_in(lfsr_map(32'h5555_1234));
        @(negedge clk);
        pulse_width_i = PW_W'(2);
        fire_en_i = 1'b1;
        repeat (40) begin
            @(negedge clk);
            fire_en_i = 1'b0;
        end
        chk(p_line_o != 0, "R8", p_line_o, 1);
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        chk(p_line_o == 0 && a_line_o == 0 && s_line_o == 0 && !done_o, "R8",
            {p_line_o, a_line_o, s_line_o, done_o}, 0);
        fire_and_watch(1, '0, 0);
        chk(last_fired == '0, "R8", last_fired, 0);
    endtask

    task automatic t_shift_during_scan();
        logic [NOZ-1:0] x = lfsr_map(32'h7777_0001);
        logic [NOZ-1:0] y = lfsr_map(32'h3141_5926);
        shift_in(x);
        fork
            fire_and_watch(30, x, 0);
            begin
                repeat (3) @(negedge clk);
                shift_in(y);
            end
        join
        chk(last_fired == x, "R9", last_fired, x);
        fire_and_watch(1, y, 0);
        chk(last_fired == y, "R9", last_fired, y);
    endtask

    task automatic t_same_cycle();
        logic [NOZ-1:0] x = lfsr_map(32'h0f0f_9999);
        logic [NOZ-1:0] y = {x[NOZ-2:0], 1'b1};
        shift_in(x);
        fire_and_watch(1, x, 1);
        chk(last_fired == x, "R10", last_fired, x);
        fire_and_watch(1, y, 0);
        chk(last_fired == y, "R10", last_fired, y);
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_patterns();
        t_zero_width();
        t_clear();
        t_shift_during_scan();
        t_same_cycle();
        summary();
    end

endmodule